// File: doc/BRIEF.md
# Table-driven serial flash sequencer

This block runs serial flash transactions whose frame layout is not fixed in hardware. It interprets a small table, loaded by software, of instruction sequences. A sequence holds up to eight slots. Each slot names one phase of the frame: a command byte, address bits, zero mode bits, idle clocks, read data, write data, or the end of the frame. Each slot also carries its own lane width of one, two or four data lines. This lets one engine produce plain single-line reads, mixed-width quad reads such as a one-line command followed by four-line address and data, and multi-line page writes.

Software fills the table one 32-bit word at a time. It then starts a transfer with one pulse that carries a sequence number, a device address, a byte count and up to four bytes of write data. The block drives chip select, a serial clock at half the system clock, and four data lines. Each line is split into output, output-enable and input pins for an external pad. Read bytes gather in a 32-bit result register, and a busy flag covers the whole transaction.

Top module: `flash_seq_top`

## Requirements
- R1: After reset, cs_n is 1, sck is 0, io_oe is 0000, busy is 0 and rd_data is 0.
- R2: Table word s*4+w holds slots 2w (bits 15:0) and 2w+1 (bits 31:16) of sequence s. A slot is opcode[15:10], lane code[9:8] and operand[7:0]. Opcodes are 0 end, 1 command, 2 address, 3/4/5 mode with 2/4/8 bits, 6 dummy, 7 read data, 8 write data.
- R3: cs_n falls on the clock edge that accepts start, and sck idles low. Each serial clock is one low and one high system cycle. Outputs change only while sck is low, and inputs are sampled at the edge where sck rises.
- R4: Lane code 0 drives io[0] (oe 0001) and reads io[1]. Code 1 uses io[1:0] (oe 0011). Code 2 or 3 uses io[3:0] (oe 1111). A phase of b bits takes ceil(b/lanes) serial clocks, and the bits go out MSB first.
- R5: A command slot sends its 8-bit operand.
- R6: An address slot sends the low N bits of dev_addr, where N is the operand, capped at 32.
- R7: A mode slot drives 2, 4 or 8 zero bits with its lanes enabled.
- R8: A dummy slot gives operand serial clocks with io_oe at 0000.
- R9: A read slot collects byte_cnt bytes (values above 4 count as 4) MSB first, right-justified in rd_data. rd_data clears when a transfer starts.
- R10: A write slot sends the low byte_cnt bytes of wr_data, most significant first. Any slot that works out to zero clocks, such as data with byte_cnt 0, is skipped.
- R11: The sequence ends at an end opcode, at an unknown opcode (9 to 63), or after slot 8. No later slot is issued.
- R12: busy rises with cs_n falling and stays high until two cycles after cs_n rises. start is ignored while busy is high, so cs_n stays high for at least two cycles between transactions.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tbl_we | input | 1 | Table word write strobe |
| tbl_addr | input | 4 | Table word index |
| tbl_wdata | input | 32 | Table word data, two slots |
| start | input | 1 | Start pulse |
| seq_sel | input | 2 | Sequence to run |
| dev_addr | input | 32 | Device address for address slots |
| byte_cnt | input | 3 | Data phase byte count |
| wr_data | input | 32 | Write bytes, low bytes used |
| busy | output | 1 | Transaction in progress |
| rd_data | output | 32 | Collected read bytes |
| cs_n | output | 1 | Chip select, active low |
| sck | output | 1 | Serial clock |
| io_out | output | 4 | Data line output values |
| io_oe | output | 4 | Data line output enables |
| io_in | input | 4 | Data line input values |

## Verification
If the slot pointer, the clock-count register or the lane register goes wrong, it shows at the pins within the same transaction. The edge count between cs_n falling and rising is off, a phase lands on the wrong lanes, or the enable pattern changes at the wrong edge. Each of these is visible on the next serial clock after the faulty slot is loaded. A corrupted shifter or capture register shows as wrong bits at a known rising edge or in rd_data as soon as busy drops. A lost end-of-frame or guard state shows as extra clocks or as a cs_n high time shorter than two cycles.

// File: rtl/flash_seq_pkg.sv
package flash_seq_pkg;

  localparam logic [5:0] OPC_END   = 6'd0;
  localparam logic [5:0] OPC_CMD   = 6'd1;
  localparam logic [5:0] OPC_ADDR  = 6'd2;
  localparam logic [5:0] OPC_MODE2 = 6'd3;
  localparam logic [5:0] OPC_MODE4 = 6'd4;
  localparam logic [5:0] OPC_MODE8 = 6'd5;
  localparam logic [5:0] OPC_DUMMY = 6'd6;
  localparam logic [5:0] OPC_RDAT  = 6'd7;
  localparam logic [5:0] OPC_WDAT  = 6'd8;

  typedef enum logic [1:0] {
    PK_OUT  = 2'd0,
    PK_IDLE = 2'd1,
    PK_IN   = 2'd2
  } phase_kind_e;

  typedef struct packed {
    phase_kind_e kind;
    logic [2:0]  lanes;   // 1, 2 or 4
    logic [7:0]  clocks;  // serial clocks in this phase
    logic [31:0] load;    // left-aligned shifter image
    logic        last;    // slot terminates the sequence
  } phase_t;

endpackage

// File: rtl/flash_seq_table.sv
module flash_seq_table #(
  parameter int DEPTH = 16,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [31:0]   wdata,
  input  logic [AW-1:0] raddr,
  output logic [31:0]   rdata
);

  logic [31:0] mem_q [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_word
    logic hit;
    assign hit = we && (waddr == AW'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   mem_q[g] <= '0;
      else if (hit) mem_q[g] <= wdata;
    end
  end

  assign rdata = mem_q[raddr];

endmodule

// File: rtl/flash_seq_decode.sv
module flash_seq_decode
  import flash_seq_pkg::*;
#(
  parameter int BC_W = 3
) (
  input  logic [15:0]     slot,
  input  logic [31:0]     dev_addr,
  input  logic [31:0]     wr_data,
  input  logic [BC_W-1:0] byte_cnt,
  output phase_t          ph
);

  logic [5:0] opc;
  logic [1:0] lcode;
  logic [7:0] opr;
  logic [7:0] bits;
  logic [7:0] nbytes;
  logic [2:0] ln;

  assign opc   = slot[15:10];
  assign lcode = slot[9:8];
  assign opr   = slot[7:0];

  always_comb begin
    ln = (lcode == 2'd0) ? 3'd1 : (lcode == 2'd1) ? 3'd2 : 3'd4;
    nbytes = (8'(byte_cnt) > 8'd4) ? 8'd4 : 8'(byte_cnt);
  end

  always_comb begin
    ph.kind   = PK_OUT;
    ph.lanes  = ln;
    ph.load   = '0;
    ph.last   = 1'b0;
    bits      = '0;
    unique case (opc)
      OPC_CMD: begin
        bits    = 8'd8;
        ph.load = {opr, 24'h0};
      end
      OPC_ADDR: begin
        bits    = (opr > 8'd32) ? 8'd32 : opr;
        ph.load = dev_addr << (8'd32 - bits);
      end
      OPC_MODE2: bits = 8'd2;
      OPC_MODE4: bits = 8'd4;
      OPC_MODE8: bits = 8'd8;
      OPC_DUMMY: ph.kind = PK_IDLE;
      OPC_RDAT: begin
        ph.kind = PK_IN;
        bits    = {nbytes[4:0], 3'b000};
      end
      OPC_WDAT: begin
        bits    = {nbytes[4:0], 3'b000};
        ph.load = wr_data << (8'd32 - bits);
      end
      default: ph.last = 1'b1;
    endcase
  end

  always_comb begin
    if (ph.kind == PK_IDLE)  ph.clocks = opr;
    else if (ln == 3'd1)     ph.clocks = bits;
    else if (ln == 3'd2)     ph.clocks = (bits + 8'd1) >> 1;
    else                     ph.clocks = (bits + 8'd3) >> 2;
  end

endmodule

// File: rtl/flash_seq_engine.sv
module flash_seq_engine
  import flash_seq_pkg::*;
#(
  parameter int SEQS     = 4,
  parameter int SLOTS    = 8,
  parameter int BC_W     = 3,
  parameter int GAP_CLKS = 2,
  localparam int WPS     = SLOTS / 2,
  localparam int DEPTH   = SEQS * WPS,
  localparam int TBL_AW  = $clog2(DEPTH),
  localparam int SEQ_W   = $clog2(SEQS),
  localparam int SLOT_AW = $clog2(SLOTS),
  localparam int GAP_W   = $clog2(GAP_CLKS + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [SEQ_W-1:0]  seq_in,
  input  logic [31:0]       addr_in,
  input  logic [BC_W-1:0]   cnt_in,
  input  logic [31:0]       wdata_in,
  output logic [TBL_AW-1:0] tbl_raddr,
  input  logic [31:0]       tbl_rdata,
  input  logic [3:0]        io_in,
  output logic              cs_n,
  output logic              sck,
  output logic [3:0]        io_out,
  output logic [3:0]        io_oe,
  output logic              busy,
  output logic [31:0]       rd_data
);

  typedef enum logic [1:0] {S_IDLE, S_LOAD, S_SHIFT, S_GAP} st_e;

  localparam logic [SLOT_AW-1:0] LAST_SLOT = SLOT_AW'(SLOTS - 1);

  st_e                st_q, st_d;
  logic [SEQ_W-1:0]   seq_q, seq_d;
  logic [31:0]        addr_q, addr_d;
  logic [BC_W-1:0]    cnt_q, cnt_d;
  logic [31:0]        wd_q, wd_d;
  logic [SLOT_AW-1:0] ptr_q, ptr_d;
  logic               half_q, half_d;
  logic [7:0]         left_q, left_d;
  logic [2:0]         lanes_q, lanes_d;
  phase_kind_e        kind_q, kind_d;
  logic [31:0]        sh_q, sh_d;
  logic [31:0]        rd_q, rd_d;
  logic               cs_n_q, cs_n_d;
  logic               sck_q, sck_d;
  logic [3:0]         oe_q, oe_d;
  logic [GAP_W-1:0]   gap_q, gap_d;
  logic               seq_done;
  logic [15:0]        cur_slot;
  phase_t             ph;

  // slot fetch: word index from sequence and pointer, half from pointer lsb
  assign tbl_raddr = TBL_AW'(seq_q) * TBL_AW'(WPS) + TBL_AW'(ptr_q >> 1);
  assign cur_slot  = ptr_q[0] ? tbl_rdata[31:16] : tbl_rdata[15:0];

  flash_seq_decode #(.BC_W(BC_W)) u_dec (
    .slot     (cur_slot),
    .dev_addr (addr_q),
    .wr_data  (wd_q),
    .byte_cnt (cnt_q),
    .ph       (ph)
  );

  function automatic logic [3:0] lane_mask(input logic [2:0] n);
    return (n == 3'd1) ? 4'b0001 : (n == 3'd2) ? 4'b0011 : 4'b1111;
  endfunction

  function automatic logic [31:0] capture(input logic [31:0] r, input logic [2:0] n,
                                          input logic [3:0] d);
    if (n == 3'd1)      return {r[30:0], d[1]};
    else if (n == 3'd2) return {r[29:0], d[1:0]};
    else                return {r[27:0], d};
  endfunction

  // next-state logic
  always_comb begin
    st_d    = st_q;    seq_d  = seq_q;  addr_d  = addr_q;  cnt_d  = cnt_q;
    wd_d    = wd_q;    ptr_d  = ptr_q;  half_d  = half_q;  left_d = left_q;
    lanes_d = lanes_q; kind_d = kind_q; sh_d    = sh_q;    rd_d   = rd_q;
    cs_n_d  = cs_n_q;  sck_d  = sck_q;  oe_d    = oe_q;    gap_d  = gap_q;
    seq_done = 1'b0;
    unique case (st_q)
      S_IDLE: begin
        if (start) begin
          seq_d  = seq_in;
          addr_d = addr_in;
          cnt_d  = cnt_in;
          wd_d   = wdata_in;
          ptr_d  = '0;
          rd_d   = '0;
          cs_n_d = 1'b0;
          st_d   = S_LOAD;
        end
      end
      S_LOAD: begin
        if (ph.last) begin
          seq_done = 1'b1;
        end else if (ph.clocks == 8'd0) begin
          if (ptr_q == LAST_SLOT) seq_done = 1'b1;
          else                    ptr_d = ptr_q + 1'b1;
        end else begin
          sh_d    = ph.load;
          left_d  = ph.clocks;
          lanes_d = ph.lanes;
          kind_d  = ph.kind;
          half_d  = 1'b0;
          oe_d    = (ph.kind == PK_OUT) ? lane_mask(ph.lanes) : 4'b0000;
          st_d    = S_SHIFT;
        end
      end
      S_SHIFT: begin
        if (!half_q) begin
          sck_d  = 1'b1;
          half_d = 1'b1;
          if (kind_q == PK_IN) rd_d = capture(rd_q, lanes_q, io_in);
        end else begin
          sck_d  = 1'b0;
          half_d = 1'b0;
          sh_d   = sh_q << lanes_q;
          left_d = left_q - 8'd1;
          if (left_q == 8'd1) begin
            oe_d = 4'b0000;
            if (ptr_q == LAST_SLOT) begin
              seq_done = 1'b1;
            end else begin
              ptr_d = ptr_q + 1'b1;
              st_d  = S_LOAD;
            end
          end
        end
      end
      S_GAP: begin
        if (gap_q == '0) st_d = S_IDLE;
        else             gap_d = gap_q - 1'b1;
      end
      default: st_d = S_IDLE;
    endcase
    if (seq_done) begin
      cs_n_d = 1'b1;
      oe_d   = 4'b0000;
      gap_d  = GAP_W'(GAP_CLKS - 1);
      st_d   = S_GAP;
    end
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= S_IDLE;  seq_q  <= '0;     addr_q <= '0;  cnt_q  <= '0;
      wd_q    <= '0;      ptr_q  <= '0;     half_q <= 1'b0; left_q <= '0;
      lanes_q <= 3'd1;    kind_q <= PK_IDLE; sh_q  <= '0;  rd_q   <= '0;
      cs_n_q  <= 1'b1;    sck_q  <= 1'b0;   oe_q   <= '0;  gap_q  <= '0;
    end else begin
      st_q    <= st_d;    seq_q  <= seq_d;  addr_q <= addr_d; cnt_q  <= cnt_d;
      wd_q    <= wd_d;    ptr_q  <= ptr_d;  half_q <= half_d; left_q <= left_d;
      lanes_q <= lanes_d; kind_q <= kind_d; sh_q   <= sh_d;   rd_q   <= rd_d;
      cs_n_q  <= cs_n_d;  sck_q  <= sck_d;  oe_q   <= oe_d;   gap_q  <= gap_d;
    end
  end

  assign cs_n    = cs_n_q;
  assign sck     = sck_q;
  assign io_oe   = oe_q;
  assign busy    = (st_q != S_IDLE);
  assign rd_data = rd_q;
  assign io_out  = (lanes_q == 3'd1) ? {3'b000, sh_q[31]} :
                   (lanes_q == 3'd2) ? {2'b00, sh_q[31:30]} : sh_q[31:28];

  // R3: clock idles low whenever the device is deselected
  a_r3_sck_low_deselected: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n_q |-> !sck_q);
  // R3: each high phase lasts exactly one system cycle
  a_r3_sck_high_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sck_q) |=> $fell(sck_q));
  // R3: driven data holds while the clock is high
  a_r3_out_stable_high: assert property (@(posedge clk) disable iff (!rst_n)
    sck_q |-> $stable(io_out));
  // R4: only the three legal enable shapes appear
  a_r4_oe_shape: assert property (@(posedge clk) disable iff (!rst_n)
    (io_oe == 4'b0000) || (io_oe == 4'b0001) || (io_oe == 4'b0011) || (io_oe == 4'b1111));
  // R8: lines float while deselected
  a_r8_float_deselected: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n_q |-> (io_oe == 4'b0000));
  // R12: selection only inside a busy window
  a_r12_cs_within_busy: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_n_q |-> busy);
  // R12: release of chip select is held for the guard time
  a_r12_gap_held: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cs_n_q) |=> cs_n_q);
  // R12: a start while busy does not change the running request
  a_r12_start_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start) |=> ($stable(seq_q) && $stable(addr_q)));

endmodule

// File: rtl/flash_seq_top.sv
module flash_seq_top
  import flash_seq_pkg::*;
#(
  parameter int SEQS     = 4,
  parameter int SLOTS    = 8,
  parameter int BC_W     = 3,
  parameter int GAP_CLKS = 2,
  localparam int WPS     = SLOTS / 2,
  localparam int DEPTH   = SEQS * WPS,
  localparam int TBL_AW  = $clog2(DEPTH),
  localparam int SEQ_W   = $clog2(SEQS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tbl_we,
  input  logic [TBL_AW-1:0] tbl_addr,
  input  logic [31:0]       tbl_wdata,
  input  logic              start,
  input  logic [SEQ_W-1:0]  seq_sel,
  input  logic [31:0]       dev_addr,
  input  logic [BC_W-1:0]   byte_cnt,
  input  logic [31:0]       wr_data,
  output logic              busy,
  output logic [31:0]       rd_data,
  output logic              cs_n,
  output logic              sck,
  output logic [3:0]        io_out,
  output logic [3:0]        io_oe,
  input  logic [3:0]        io_in
);

  logic [1:0]        rst_sync_q;
  logic              rst_n_i;
  logic [TBL_AW-1:0] tbl_raddr;
  logic [31:0]       tbl_rdata;

  // reset asserts at once, releases on a clock edge
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_i = rst_sync_q[1];

  flash_seq_table #(.DEPTH(DEPTH), .AW(TBL_AW)) u_tbl (
    .clk   (clk),
    .rst_n (rst_n_i),
    .we    (tbl_we),
    .waddr (tbl_addr),
    .wdata (tbl_wdata),
    .raddr (tbl_raddr),
    .rdata (tbl_rdata)
  );

  flash_seq_engine #(
    .SEQS(SEQS), .SLOTS(SLOTS), .BC_W(BC_W), .GAP_CLKS(GAP_CLKS)
  ) u_eng (
    .clk       (clk),
    .rst_n     (rst_n_i),
    .start     (start),
    .seq_in    (seq_sel),
    .addr_in   (dev_addr),
    .cnt_in    (byte_cnt),
    .wdata_in  (wr_data),
    .tbl_raddr (tbl_raddr),
    .tbl_rdata (tbl_rdata),
    .io_in     (io_in),
    .cs_n      (cs_n),
    .sck       (sck),
    .io_out    (io_out),
    .io_oe     (io_oe),
    .busy      (busy),
    .rd_data   (rd_data)
  );

endmodule

// File: tb/sim_flash_seq_top.sv
module sim_flash_seq_top;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        tbl_we;
  logic [3:0]  tbl_addr;
  logic [31:0] tbl_wdata;
  logic        start;
  logic [1:0]  seq_sel;
  logic [31:0] dev_addr;
  logic [2:0]  byte_cnt;
  logic [31:0] wr_data;
  logic        busy;
  logic [31:0] rd_data;
  logic        cs_n;
  logic        sck;
  logic [3:0]  io_out;
  logic [3:0]  io_oe;
  logic [3:0]  io_in;

  int n_chk = 0;
  int n_fail = 0;

  flash_seq_top u0 (
    .clk(clk), .rst_n(rst_n), .tbl_we(tbl_we), .tbl_addr(tbl_addr),
    .tbl_wdata(tbl_wdata), .start(start), .seq_sel(seq_sel),
    .dev_addr(dev_addr), .byte_cnt(byte_cnt), .wr_data(wr_data),
    .busy(busy), .rd_data(rd_data), .cs_n(cs_n), .sck(sck),
    .io_out(io_out), .io_oe(io_oe), .io_in(io_in)
  );

  always #4 clk = ~clk;

  // device model: responds with a pattern indexed by rising sck count
  function automatic logic [3:0] resp(input int k);
    return 4'((k * 7 + 5) % 16);
  endfunction

  int         nrise;
  logic [3:0] log_v  [128];
  logic [3:0] log_oe [128];

  always @(posedge sck or negedge cs_n) begin
    if (sck) begin
      if (nrise < 128) begin
        log_v[nrise]  <= io_out & io_oe;
        log_oe[nrise] <= io_oe;
      end
      nrise <= nrise + 1;
    end else begin
      nrise <= 0;
    end
  end

  assign io_in = cs_n ? 4'h0 : resp(nrise);

  int hi_cnt;
  int min_hi;
  always @(posedge clk) begin
    if (!rst_n) begin
      hi_cnt <= 0;
      min_hi <= 999;
    end else if (cs_n) begin
      hi_cnt <= hi_cnt + 1;
    end else begin
      if (hi_cnt != 0 && hi_cnt < min_hi) min_hi <= hi_cnt;
      hi_cnt <= 0;
    end
  end

  // expected frame
  logic [3:0] exp_v  [128];
  logic [3:0] exp_oe [128];
  int         en;

  task automatic chk(input string tag, input bit ok, input logic [31:0] act,
                     input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic exp_clear();
    en = 0;
  endtask

  task automatic exp_out(input logic [31:0] v, input int bits, input int ln);
    logic [31:0] s;
    int cyc;
    s = v << (32 - bits);
    cyc = (bits + ln - 1) / ln;
    for (int i = 0; i < cyc; i++) begin
      if (ln == 1)      begin exp_v[en] = {3'b000, s[31]};    exp_oe[en] = 4'b0001; end
      else if (ln == 2) begin exp_v[en] = {2'b00, s[31:30]};  exp_oe[en] = 4'b0011; end
      else              begin exp_v[en] = s[31:28];           exp_oe[en] = 4'b1111; end
      s = s << ln;
      en++;
    end
  endtask

  task automatic exp_idle(input int n);
    for (int i = 0; i < n; i++) begin
      exp_v[en] = 4'h0; exp_oe[en] = 4'h0; en++;
    end
  endtask

  function automatic logic [31:0] exp_rd(input int first, input int ncl, input int ln);
    logic [31:0] r;
    logic [3:0] d;
    r = '0;
    for (int k = 0; k < ncl; k++) begin
      d = resp(first + k);
      if (ln == 1)      r = {r[30:0], d[1]};
      else if (ln == 2) r = {r[29:0], d[1:0]};
      else              r = {r[27:0], d};
    end
    return r;
  endfunction

  task automatic check_frame(input string tag);
    int bad;
    bad = -1;
    chk({tag, " clock count"}, nrise == en, 32'(nrise), 32'(en));
    for (int i = 0; i < en && i < 128; i++)
      if (bad < 0 && (log_v[i] !== exp_v[i] || log_oe[i] !== exp_oe[i])) bad = i;
    if (bad < 0) chk({tag, " lane data"}, 1'b1, 0, 0);
    else chk({tag, " lane data"}, 1'b0, {20'h0, bad[3:0], log_oe[bad], log_v[bad]},
             {20'h0, bad[3:0], exp_oe[bad], exp_v[bad]});
  endtask

  function automatic logic [15:0] slot(input int op, input int ln, input int opr);
    return {op[5:0], ln[1:0], opr[7:0]};
  endfunction

  task automatic wr_tbl(input int a, input logic [15:0] hi, input logic [15:0] lo);
    @(negedge clk);
    tbl_we = 1'b1; tbl_addr = 4'(a); tbl_wdata = {hi, lo};
    @(negedge clk);
    tbl_we = 1'b0;
  endtask

  task automatic launch(input int s, input logic [31:0] a, input int c,
                        input logic [31:0] w, input string tag);
    @(negedge clk);
    seq_sel = 2'(s); dev_addr = a; byte_cnt = 3'(c); wr_data = w; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk({tag, " R12 busy and R3 select after start"}, busy && !cs_n, {30'h0, busy, cs_n}, 32'h2);
    while (busy) @(negedge clk);
  endtask

  // ---------------- scenarios ----------------
  task automatic t_reset();
    chk("R1 cs_n idle", cs_n == 1'b1, 32'(cs_n), 1);
    chk("R1 sck low", sck == 1'b0, 32'(sck), 0);
    chk("R1 no drive", io_oe == 4'h0, 32'(io_oe), 0);
    chk("R1 busy low", busy == 1'b0, 32'(busy), 0);
    chk("R1 rd_data zero", rd_data == 32'h0, rd_data, 0);
  endtask

  task automatic t_single_read();
    launch(0, 32'h12A5C3E7, 2, 32'h0, "single read");
    exp_clear(); exp_out(32'h03, 8, 1); exp_out(32'hA5C3E7, 24, 1); exp_idle(16);
    check_frame("R5 R6 R2 single-line read frame");
    chk("R9 single-line read data on io1", rd_data == exp_rd(32, 16, 1), rd_data, exp_rd(32, 16, 1));
    chk("R3 deselected after run", cs_n == 1'b1 && sck == 1'b0, {30'h0, cs_n, sck}, 32'h2);
  endtask

  task automatic t_quad_read();
    launch(1, 32'hFF3C5A96, 4, 32'h0, "quad read");
    exp_clear(); exp_out(32'hEB, 8, 1); exp_out(32'h3C5A96, 24, 4);
    exp_out(32'h0, 8, 4); exp_idle(4); exp_idle(8);
    check_frame("R4 R7 R8 quad read frame");
    chk("R9 quad read data", rd_data == exp_rd(20, 8, 4), rd_data, exp_rd(20, 8, 4));
  endtask

  task automatic t_dual_write();
    launch(2, 32'hDEADBEEF, 3, 32'h77A1B2C3, "dual write");
    exp_clear(); exp_out(32'hA2, 8, 1); exp_out(32'hDEADBEEF, 32, 1);
    exp_out(32'hA1B2C3, 24, 2);
    check_frame("R10 R6 R11 dual write, unknown opcode ends");
  endtask

  task automatic t_eight_slots();
    launch(3, 32'h0, 0, 32'h0, "eight slots");
    exp_clear();
    for (int i = 1; i <= 8; i++) exp_out(32'(i * 8'h11), 8, 1);
    check_frame("R11 ends after slot 8");
  endtask

  task automatic t_zero_count();
    launch(0, 32'h00010203, 0, 32'h0, "zero count");
    exp_clear(); exp_out(32'h03, 8, 1); exp_out(32'h010203, 24, 1);
    check_frame("R10 zero byte count skips data slot");
    chk("R9 rd_data cleared at start", rd_data == 32'h0, rd_data, 0);
  endtask

  task automatic t_count_clamp();
    launch(1, 32'h00000001, 7, 32'h0, "count clamp");
    exp_clear(); exp_out(32'hEB, 8, 1); exp_out(32'h000001, 24, 4);
    exp_out(32'h0, 8, 4); exp_idle(4); exp_idle(8);
    check_frame("R9 byte count above 4 acts as 4");
  endtask

  task automatic t_start_ignored();
    @(negedge clk);
    seq_sel = 2'd0; dev_addr = 32'h00ABCDEF; byte_cnt = 3'd2; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (30) @(negedge clk);
    seq_sel = 2'd3; dev_addr = 32'h0; byte_cnt = 3'd0; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    while (busy) @(negedge clk);
    exp_clear(); exp_out(32'h03, 8, 1); exp_out(32'hABCDEF, 24, 1); exp_idle(16);
    check_frame("R12 start while busy ignored");
    chk("R12 read unaffected by ignored start", rd_data == exp_rd(32, 16, 1), rd_data, exp_rd(32, 16, 1));
  endtask

  task automatic t_back_to_back();
    @(negedge clk);
    seq_sel = 2'd3; start = 1'b1;
    @(negedge clk);
    seq_sel = 2'd0; dev_addr = 32'h00112233; byte_cnt = 3'd1;
    while (cs_n == 1'b0) @(negedge clk);
    chk("R12 busy held as cs_n rises", busy == 1'b1, 32'(busy), 1);
    while (cs_n == 1'b1) @(negedge clk);
    start = 1'b0;
    while (busy) @(negedge clk);
    chk("R12 guard time between transactions", min_hi >= 2, 32'(min_hi), 2);
    exp_clear(); exp_out(32'h03, 8, 1); exp_out(32'h112233, 24, 1); exp_idle(8);
    check_frame("R12 back-to-back second frame");
  endtask

  initial begin
    #(8 * 150000);
    n_fail++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0; tbl_we = 1'b0; tbl_addr = '0; tbl_wdata = '0; start = 1'b0;
    seq_sel = '0; dev_addr = '0; byte_cnt = '0; wr_data = '0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    // R2: table layout, sequence s at words s*4..s*4+3
    wr_tbl(0,  slot(2, 0, 24),   slot(1, 0, 8'h03));
    wr_tbl(1,  slot(0, 0, 0),    slot(7, 0, 0));
    wr_tbl(4,  slot(2, 2, 24),   slot(1, 0, 8'hEB));
    wr_tbl(5,  slot(6, 0, 4),    slot(5, 2, 0));
    wr_tbl(6,  slot(0, 0, 0),    slot(7, 2, 0));
    wr_tbl(8,  slot(2, 0, 32),   slot(1, 0, 8'hA2));
    wr_tbl(9,  slot(12, 0, 0),   slot(8, 1, 0));
    wr_tbl(10, slot(0, 0, 0),    slot(1, 0, 8'h55));
    wr_tbl(12, slot(1, 0, 8'h22), slot(1, 0, 8'h11));
    wr_tbl(13, slot(1, 0, 8'h44), slot(1, 0, 8'h33));
    wr_tbl(14, slot(1, 0, 8'h66), slot(1, 0, 8'h55));
    wr_tbl(15, slot(1, 0, 8'h88), slot(1, 0, 8'h77));
    t_single_read();
    t_quad_read();
    t_dual_write();
    t_eight_slots();
    t_zero_count();
    t_count_clamp();
    t_start_ignored();
    t_back_to_back();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

endmodule